// File: doc/BRIEF.md
# Reset cause status tracker

This block keeps a set of sticky flags that tell firmware why a processor core last restarted or woke from a low-power state. It also chooses the program address the core continues from. Single-cycle strobes report each cause: power-on, brown-out, the software reset instruction, an external clear, a watchdog time-out, a stack-full event, a stack-underflow event and an interrupt wake. Each cause sets some flags, clears some and leaves the rest alone. The effect depends on the current power mode, which is full power, low-power run, idle or sleep.

Restarts resume at the reset address. A watchdog time-out in idle or sleep wakes the core instead. So does an interrupt that ends a power-managed mode. Such a wake resumes at the current PC plus 2, or at an interrupt vector when interrupts are globally enabled. A soft brown-out enable bit follows the brown-out configuration field. Firmware can overwrite the flags through a simple write port. A hardware cause in the same cycle wins for the bits it changes.

All outputs are registered and change on the clock edge that samples the cause. When several causes arrive together, only the one with the highest priority is applied.

Top module: `rst_cause_tracker`

## Requirements
- R1: While rst_n is low, flags_o is 7'h1C, sboren_o is 0, restart_o and wake_o are 0, and resume_addr_o is 0.
  - The flag bit positions are: [6] stack underflow, [5] stack overflow, [4] reset-instruction, [3] time-out, [2] power-down, [1] power-on, [0] brown-out.
- R2: A power-on strobe loads flags_o with 7'h1C. This sets reset-instruction, time-out and power-down, and clears the other four flags. It also pulses restart_o with resume address 0. It loads sboren_o with 1 when bor_cfg_i is 2'b01 and with 0 otherwise.
- R3: A brown-out sets the reset-instruction, time-out and power-down flags. It clears the brown-out flag, holds the power-on and stack flags, and restarts at 0.
- R4: An external clear restarts at 0. Its effect on the flags depends on the mode (pmode_i: 00 full, 01 low-power run, 10 idle, 11 sleep):
  - in full power it changes no flag;
  - in low-power run it sets time-out;
  - in idle or sleep it sets time-out and clears power-down.
- R5: A watchdog time-out in full power or low-power run clears only time-out and restarts at 0.
- R6: A watchdog time-out in idle or sleep clears time-out and power-down. It pulses wake_o instead of restart_o, and sets resume_addr_o to pc_i + 2, modulo 2^PC_W.
- R7: An interrupt wake in low-power run, idle or sleep clears only power-down and pulses wake_o. The resume address is chosen by the interrupt enables:
  - 0x008 when gie_hi_i is 1;
  - otherwise 0x018 when gie_lo_i is 1;
  - otherwise pc_i + 2.

  In full power an interrupt wake is ignored.
- R8: A stack-full strobe sets the overflow flag, and a stack-underflow strobe sets the underflow flag. Either one restarts at 0 only when stk_rst_en_i is 1. With stk_rst_en_i at 0, neither restart_o nor wake_o pulses.
- R9: The reset instruction clears only the reset-instruction flag and restarts at 0.
- R10: On every restart other than power-on, sboren_o holds its value when bor_cfg_i is 2'b01 and becomes 0 otherwise. Wakes never change sboren_o.
- R11: A software write loads sw_wdata_i into flags_o at the next edge. For the bits that a hardware cause in the same cycle sets or clears, the cause's value wins. With no cause and no write, flags_o holds.
- R12: Simultaneous causes are resolved in this fixed order, and only the winner is applied: power-on, brown-out, external clear, watchdog, stack-full, stack-underflow, reset instruction, interrupt wake.
- R13: restart_o and wake_o are never high together. Each is high for exactly the cycle after its cause was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on strobe |
| bor_i | input | 1 | Brown-out strobe |
| rst_instr_i | input | 1 | Reset instruction strobe |
| ext_clr_i | input | 1 | External clear strobe |
| wdt_to_i | input | 1 | Watchdog time-out strobe |
| stk_full_i | input | 1 | Stack-full strobe |
| stk_unf_i | input | 1 | Stack-underflow strobe |
| int_wake_i | input | 1 | Interrupt wake strobe |
| pmode_i | input | 2 | Power mode: 00 full, 01 low-power run, 10 idle, 11 sleep |
| stk_rst_en_i | input | 1 | Stack events cause a restart when 1 |
| bor_cfg_i | input | 2 | Brown-out configuration field |
| gie_hi_i | input | 1 | High-priority global interrupt enable |
| gie_lo_i | input | 1 | Low-priority global interrupt enable |
| pc_i | input | PC_W | Current program counter |
| sw_we_i | input | 1 | Software write strobe for the flags |
| sw_wdata_i | input | 7 | Software write data |
| flags_o | output | 7 | Sticky flag register |
| sboren_o | output | 1 | Soft brown-out enable bit |
| restart_o | output | 1 | Restart request pulse |
| wake_o | output | 1 | Wake-up resume pulse |
| resume_addr_o | output | PC_W | Address to continue from |

## Verification
The bench goes after the mode-dependent branches:
- An external clear in full power must leave every flag alone. A design that set time-out there would show a changed flag byte.
- A watchdog time-out in sleep must wake rather than restart. Treating it as a restart would give address 0 and a restart pulse instead of pc_i + 2.
- A wake at pc_i = 0xFFFF checks that the PC + 2 target wraps.
- The bench tries every combination of the two interrupt enables. It also sends an interrupt in full power, which a sloppy design would turn into a spurious wake.
- Colliding causes and a software write in the same cycle as a cause expose a wrong priority or a write that overrides hardware. Either shows up as wrong flag values.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
   localparam int NFLAG = 7;
   localparam int F_BOR = 0;
   localparam int F_POR = 1;
   localparam int F_PD  = 2;
   localparam int F_TO  = 3;
   localparam int F_RI  = 4;
   localparam int F_OVF = 5;
   localparam int F_UNF = 6;

   // cause indices in priority order, lowest index wins
   localparam int NEV     = 8;
   localparam int EV_POR  = 0;
   localparam int EV_BOR  = 1;
   localparam int EV_XCLR = 2;
   localparam int EV_WDT  = 3;
   localparam int EV_SFUL = 4;
   localparam int EV_SUNF = 5;
   localparam int EV_RI   = 6;
   localparam int EV_INT  = 7;

   typedef enum logic [1:0] {
      PM_FULL  = 2'b00,
      PM_LPRUN = 2'b01,
      PM_IDLE  = 2'b10,
      PM_SLEEP = 2'b11
   } pmode_e;

   typedef enum logic [1:0] {
      ACT_NONE    = 2'b00,
      ACT_RESTART = 2'b01,
      ACT_WAKE    = 2'b10
   } act_e;

   typedef enum logic [1:0] {
      DST_ZERO = 2'b00,
      DST_PC2  = 2'b01,
      DST_VHI  = 2'b10,
      DST_VLO  = 2'b11
   } dst_e;

   typedef struct packed {
      logic [NFLAG-1:0] set;
      logic [NFLAG-1:0] clr;
      act_e             act;
      dst_e             dst;
   } eff_t;
endpackage

// File: rtl/rcause_prio.sv
module rcause_prio #(
   parameter int N = 8
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);
   logic [N:0] blocked;

   assign blocked[0] = 1'b0;

   generate
      if (N < 1) begin : g_bad_n
         $error("rcause_prio: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign grant_o[i]   = req_i[i] & ~blocked[i];
         assign blocked[i+1] = blocked[i] | req_i[i];
      end
   endgenerate
endmodule

// File: rtl/rcause_effect.sv
module rcause_effect
   import rcause_pkg::*;
(
   input  logic [NEV-1:0] grant_i,
   input  pmode_e         pmode_i,
   input  logic           stk_rst_en_i,
   input  logic           gie_hi_i,
   input  logic           gie_lo_i,
   output eff_t           eff_o
);
   logic low_pwr;

   assign low_pwr = (pmode_i == PM_IDLE) || (pmode_i == PM_SLEEP);

   always_comb begin
      eff_o = '{set: '0, clr: '0, act: ACT_NONE, dst: DST_ZERO};
      if (grant_i[EV_POR]) begin
         eff_o.set = '0;
         eff_o.set[F_RI] = 1'b1;
         eff_o.set[F_TO] = 1'b1;
         eff_o.set[F_PD] = 1'b1;
         eff_o.clr = ~eff_o.set;
         eff_o.act = ACT_RESTART;
      end else if (grant_i[EV_BOR]) begin
         eff_o.set[F_RI]  = 1'b1;
         eff_o.set[F_TO]  = 1'b1;
         eff_o.set[F_PD]  = 1'b1;
         eff_o.clr[F_BOR] = 1'b1;
         eff_o.act = ACT_RESTART;
      end else if (grant_i[EV_XCLR]) begin
         if (pmode_i != PM_FULL) begin
            eff_o.set[F_TO] = 1'b1;
         end
         if (low_pwr) begin
            eff_o.clr[F_PD] = 1'b1;
         end
         eff_o.act = ACT_RESTART;
      end else if (grant_i[EV_WDT]) begin
         eff_o.clr[F_TO] = 1'b1;
         if (low_pwr) begin
            eff_o.clr[F_PD] = 1'b1;
            eff_o.act = ACT_WAKE;
            eff_o.dst = DST_PC2;
         end else begin
            eff_o.act = ACT_RESTART;
         end
      end else if (grant_i[EV_SFUL]) begin
         eff_o.set[F_OVF] = 1'b1;
         eff_o.act = stk_rst_en_i ? ACT_RESTART : ACT_NONE;
      end else if (grant_i[EV_SUNF]) begin
         eff_o.set[F_UNF] = 1'b1;
         eff_o.act = stk_rst_en_i ? ACT_RESTART : ACT_NONE;
      end else if (grant_i[EV_RI]) begin
         eff_o.clr[F_RI] = 1'b1;
         eff_o.act = ACT_RESTART;
      end else if (grant_i[EV_INT]) begin
         eff_o.clr[F_PD] = 1'b1;
         eff_o.act = ACT_WAKE;
         if (gie_hi_i) begin
            eff_o.dst = DST_VHI;
         end else if (gie_lo_i) begin
            eff_o.dst = DST_VLO;
         end else begin
            eff_o.dst = DST_PC2;
         end
      end
   end
endmodule

// File: rtl/rcause_flags.sv
module rcause_flags #(
   parameter int             W       = 7,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sw_we_i,
   input  logic [W-1:0] sw_wdata_i,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_o[b] <= RST_VAL[b];
            end else if (set_i[b]) begin
               q_o[b] <= 1'b1;
            end else if (clr_i[b]) begin
               q_o[b] <= 1'b0;
            end else if (sw_we_i) begin
               q_o[b] <= sw_wdata_i[b];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rcause_resume.sv
module rcause_resume
   import rcause_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int RST_VEC = 0,
   parameter int VEC_HI  = 8,
   parameter int VEC_LO  = 24,
   parameter int PC_STEP = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  act_e            act_i,
   input  dst_e            dst_i,
   input  logic [PC_W-1:0] pc_i,
   output logic            restart_o,
   output logic            wake_o,
   output logic [PC_W-1:0] addr_o
);
   localparam logic [PC_W-1:0] A_RST  = PC_W'(RST_VEC);
   localparam logic [PC_W-1:0] A_HI   = PC_W'(VEC_HI);
   localparam logic [PC_W-1:0] A_LO   = PC_W'(VEC_LO);
   localparam logic [PC_W-1:0] A_STEP = PC_W'(PC_STEP);

   generate
      if (PC_W < 5 || PC_W > 32) begin : g_bad_w
         $error("rcause_resume: PC_W out of range");
      end
      if (VEC_LO >= (1 << PC_W) || VEC_HI >= (1 << PC_W)) begin : g_bad_vec
         $error("rcause_resume: vector does not fit PC_W");
      end
   endgenerate

   logic [PC_W-1:0] target;

   always_comb begin
      unique case (dst_i)
         DST_PC2: target = pc_i + A_STEP;
         DST_VHI: target = A_HI;
         DST_VLO: target = A_LO;
         default: target = A_RST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         restart_o <= 1'b0;
         wake_o    <= 1'b0;
         addr_o    <= A_RST;
      end else begin
         restart_o <= (act_i == ACT_RESTART);
         wake_o    <= (act_i == ACT_WAKE);
         if (act_i == ACT_RESTART) begin
            addr_o <= A_RST;
         end else if (act_i == ACT_WAKE) begin
            addr_o <= target;
         end
      end
   end
endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
   import rcause_pkg::*;
#(
   parameter int         PC_W       = 16,
   parameter int         RST_VEC    = 0,
   parameter int         VEC_HI     = 8,
   parameter int         VEC_LO     = 24,
   parameter logic [1:0] BOR_SW_CFG = 2'b01
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            por_i,
   input  logic            bor_i,
   input  logic            rst_instr_i,
   input  logic            ext_clr_i,
   input  logic            wdt_to_i,
   input  logic            stk_full_i,
   input  logic            stk_unf_i,
   input  logic            int_wake_i,
   input  logic [1:0]      pmode_i,
   input  logic            stk_rst_en_i,
   input  logic [1:0]      bor_cfg_i,
   input  logic            gie_hi_i,
   input  logic            gie_lo_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic            sw_we_i,
   input  logic [6:0]      sw_wdata_i,
   output logic [6:0]      flags_o,
   output logic            sboren_o,
   output logic            restart_o,
   output logic            wake_o,
   output logic [PC_W-1:0] resume_addr_o
);
   localparam logic [NFLAG-1:0] FLAG_RST =
      NFLAG'((1 << F_RI) | (1 << F_TO) | (1 << F_PD));

   pmode_e         pmode;
   logic [NEV-1:0] req;
   logic [NEV-1:0] grant;
   eff_t           eff;

   assign pmode = pmode_e'(pmode_i);

   always_comb begin
      req          = '0;
      req[EV_POR]  = por_i;
      req[EV_BOR]  = bor_i;
      req[EV_XCLR] = ext_clr_i;
      req[EV_WDT]  = wdt_to_i;
      req[EV_SFUL] = stk_full_i;
      req[EV_SUNF] = stk_unf_i;
      req[EV_RI]   = rst_instr_i;
      req[EV_INT]  = int_wake_i && (pmode != PM_FULL);
   end

   rcause_prio #(.N(NEV)) u_prio (
      .req_i   (req),
      .grant_o (grant)
   );

   rcause_effect u_eff (
      .grant_i      (grant),
      .pmode_i      (pmode),
      .stk_rst_en_i (stk_rst_en_i),
      .gie_hi_i     (gie_hi_i),
      .gie_lo_i     (gie_lo_i),
      .eff_o        (eff)
   );

   rcause_flags #(.W(NFLAG), .RST_VAL(FLAG_RST)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_we_i    (sw_we_i),
      .sw_wdata_i (sw_wdata_i),
      .set_i      (eff.set),
      .clr_i      (eff.clr),
      .q_o        (flags_o)
   );

   rcause_resume #(
      .PC_W    (PC_W),
      .RST_VEC (RST_VEC),
      .VEC_HI  (VEC_HI),
      .VEC_LO  (VEC_LO),
      .PC_STEP (2)
   ) u_resume (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (eff.act),
      .dst_i     (eff.dst),
      .pc_i      (pc_i),
      .restart_o (restart_o),
      .wake_o    (wake_o),
      .addr_o    (resume_addr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sboren_o <= 1'b0;
      end else if (eff.act == ACT_RESTART) begin
         if (grant[EV_POR]) begin
            sboren_o <= (bor_cfg_i == BOR_SW_CFG);
         end else if (bor_cfg_i != BOR_SW_CFG) begin
            sboren_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rcause_chk.sv
module rcause_chk #(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            por_i,
   input logic            bor_i,
   input logic            rst_instr_i,
   input logic            ext_clr_i,
   input logic            wdt_to_i,
   input logic            stk_full_i,
   input logic            stk_unf_i,
   input logic            int_wake_i,
   input logic [1:0]      pmode_i,
   input logic            stk_rst_en_i,
   input logic [1:0]      bor_cfg_i,
   input logic [PC_W-1:0] pc_i,
   input logic            sw_we_i,
   input logic [6:0]      flags_o,
   input logic            sboren_o,
   input logic            restart_o,
   input logic            wake_o,
   input logic [PC_W-1:0] resume_addr_o
);
   logic above_wdt;
   logic above_ri;
   logic quiet;

   assign above_wdt = por_i | bor_i | ext_clr_i;
   assign above_ri  = above_wdt | wdt_to_i | stk_full_i | stk_unf_i;
   assign quiet     = ~(above_ri | rst_instr_i | int_wake_i | sw_we_i);

   a_r2_por_load: assert property (@(posedge clk) disable iff (!rst_n)
      por_i |=> (flags_o == 7'h1C) && restart_o && (resume_addr_o == '0));

   a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_clr_i && !por_i && !bor_i && pmode_i == 2'b00 && !sw_we_i)
      |=> (flags_o == $past(flags_o)) && restart_o);

   a_r6_wdt_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_to_i && !above_wdt && pmode_i[1])
      |=> wake_o && !restart_o && !flags_o[3] && !flags_o[2]
          && (resume_addr_o == PC_W'($past(pc_i) + PC_W'(2))));

   a_r8_no_stk_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_unf_i && !stk_full_i && !above_wdt && !wdt_to_i && !stk_rst_en_i)
      |=> !restart_o && !wake_o && flags_o[6]);

   a_r9_ri_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_instr_i && !above_ri) |=> !flags_o[4] && restart_o);

   a_r10_sboren_off: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_o && $past(bor_cfg_i) != 2'b01) |-> !sboren_o);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> $stable(flags_o) && !restart_o && !wake_o);

   a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(restart_o && wake_o));
endmodule

bind rst_cause_tracker rcause_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/rst_cause_tracker_bench.sv
`timescale 1ns/1ps
module rst_cause_tracker_bench;
   localparam int PC_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por, bor, rsti, xclr, wdt, sful, sunf, intw;
   logic [1:0] pm, cfg;
   logic stv, ghi, glo, swe;
   logic [PC_W-1:0] pc;
   logic [6:0] swd;
   logic [6:0] flags;
   logic sb, rs, wk;
   logic [PC_W-1:0] addr;

   int checks = 0;
   int errors = 0;

   logic [6:0] ef;
   logic esb, ers, ewk;
   logic [PC_W-1:0] ead;
   string tag;

   always #2.5 clk = ~clk;

   rst_cause_tracker #(.PC_W(PC_W)) u_rst_cause_tracker (
      .clk(clk), .rst_n(rst_n), .por_i(por), .bor_i(bor), .rst_instr_i(rsti),
      .ext_clr_i(xclr), .wdt_to_i(wdt), .stk_full_i(sful), .stk_unf_i(sunf),
      .int_wake_i(intw), .pmode_i(pm), .stk_rst_en_i(stv), .bor_cfg_i(cfg),
      .gie_hi_i(ghi), .gie_lo_i(glo), .pc_i(pc), .sw_we_i(swe), .sw_wdata_i(swd),
      .flags_o(flags), .sboren_o(sb), .restart_o(rs), .wake_o(wk),
      .resume_addr_o(addr)
   );

   task automatic do_restart();
      ers = 1'b1;
      ead = '0;
      if (cfg != 2'b01) esb = 1'b0;
   endtask

   task automatic predict();
      logic [6:0] f;
      int nq;
      f = swe ? swd : ef;
      ers = 1'b0;
      ewk = 1'b0;
      nq = int'(por) + int'(bor) + int'(xclr) + int'(wdt) + int'(sful)
         + int'(sunf) + int'(rsti) + int'(intw && pm != 2'b00);
      tag = "R13";
      if (por) begin
         f = 7'h1C; ers = 1'b1; ead = '0; esb = (cfg == 2'b01); tag = "R2";
      end else if (bor) begin
         f = f | 7'h1C; f[0] = 1'b0; do_restart(); tag = "R3 R10";
      end else if (xclr) begin
         if (pm != 2'b00) f[3] = 1'b1;
         if (pm[1]) f[2] = 1'b0;
         do_restart(); tag = "R4 R10";
      end else if (wdt) begin
         f[3] = 1'b0;
         if (pm[1]) begin
            f[2] = 1'b0; ewk = 1'b1; ead = pc + 16'd2; tag = "R6";
         end else begin
            do_restart(); tag = "R5 R10";
         end
      end else if (sful) begin
         f[5] = 1'b1; if (stv) do_restart(); tag = "R8";
      end else if (sunf) begin
         f[6] = 1'b1; if (stv) do_restart(); tag = "R8";
      end else if (rsti) begin
         f[4] = 1'b0; do_restart(); tag = "R9 R10";
      end else if (intw) begin
         tag = "R7";
         if (pm != 2'b00) begin
            f[2] = 1'b0; ewk = 1'b1;
            ead = ghi ? 16'h0008 : (glo ? 16'h0018 : pc + 16'd2);
         end
      end
      if (nq > 1) tag = {tag, " R12"};
      if (swe) tag = {tag, " R11"};
      ef = f;
   endtask

   task automatic compare(input string t);
      checks++;
      if ({flags, sb, rs, wk, addr} !== {ef, esb, ers, ewk, ead}) begin
         errors++;
         $display("FAIL %s: got flags=%h sb=%b rs=%b wk=%b addr=%h exp flags=%h sb=%b rs=%b wk=%b addr=%h",
                  t, flags, sb, rs, wk, addr, ef, esb, ers, ewk, ead);
      end
   endtask

   task automatic go();
      predict();
      @(negedge clk);
      compare(tag);
      {por, bor, rsti, xclr, wdt, sful, sunf, intw, swe} = '0;
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      {por, bor, rsti, xclr, wdt, sful, sunf, intw, swe, stv, ghi, glo} = '0;
      pm = 2'b00; cfg = 2'b01; pc = 16'h1234; swd = '0;
      ef = 7'h1C; esb = 1'b0; ers = 1'b0; ewk = 1'b0; ead = '0;
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;

      por = 1'b1; go();                                   // R2 with cfg 01
      bor = 1'b1; go();                                   // R3 sboren holds
      swe = 1'b1; swd = 7'h7F; go();                      // R11
      xclr = 1'b1; pm = 2'b00; go();                      // R4 full power
      swe = 1'b1; swd = 7'h00; go();
      xclr = 1'b1; pm = 2'b01; go();                      // R4 low-power run
      swe = 1'b1; swd = 7'h04; go();
      xclr = 1'b1; pm = 2'b10; go();                      // R4 idle
      wdt = 1'b1; pm = 2'b00; go();                       // R5
      wdt = 1'b1; pm = 2'b11; pc = 16'hFFFF; go();        // R6 wrap
      intw = 1'b1; pm = 2'b00; go();                      // R7 ignored
      intw = 1'b1; pm = 2'b10; pc = 16'h0100; go();       // R7 pc+2
      intw = 1'b1; ghi = 1'b1; go();                      // R7 high vector
      intw = 1'b1; ghi = 1'b0; glo = 1'b1; go();          // R7 low vector
      intw = 1'b1; ghi = 1'b1; glo = 1'b1; go();          // R7 high wins
      ghi = 1'b0; glo = 1'b0;
      sful = 1'b1; stv = 1'b1; go();                      // R8 restart
      sunf = 1'b1; stv = 1'b0; go();                      // R8 no restart
      rsti = 1'b1; go();                                  // R9
      bor = 1'b1; cfg = 2'b10; go();                      // R10 sboren drops
      por = 1'b1; bor = 1'b1; cfg = 2'b01; go();          // R12
      wdt = 1'b1; rsti = 1'b1; pm = 2'b11; go();          // R12 wake wins
      bor = 1'b1; swe = 1'b1; swd = 7'h43; go();          // R11 with R12-free override

      void'($urandom(32'd20240611));
      for (int n = 0; n < 3000; n++) begin
         por  = ($urandom % 64) == 0;
         bor  = ($urandom % 32) == 0;
         xclr = ($urandom % 12) == 0;
         wdt  = ($urandom % 12) == 0;
         sful = ($urandom % 12) == 0;
         sunf = ($urandom % 12) == 0;
         rsti = ($urandom % 12) == 0;
         intw = ($urandom % 6) == 0;
         swe  = ($urandom % 8) == 0;
         swd  = 7'($urandom);
         pm   = 2'($urandom);
         stv  = 1'($urandom);
         ghi  = ($urandom % 3) == 0;
         glo  = ($urandom % 3) == 0;
         pc   = 16'($urandom);
         cfg  = (($urandom % 4) == 0) ? 2'($urandom) : 2'b01;
         go();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule